// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host read and write a small bank of 8-bit registers over a four-wire serial port. The port carries chip select, serial clock, data in and data out, and chip select is active low. Every access is one frame of exactly sixteen serial clocks. The first eight clocks carry the direction and the register address. The last eight carry the data byte, least significant bit first. Chip select must return high after each frame, so one frame carries exactly one access.

The serial pins are oversampled in the system clock domain. Each one passes through a short synchronizer, and edge detection turns the serial clock into rising and falling strobes. Register 0 is a read-only view of the alarm inputs. An active-low interrupt output reports any change of those alarms, and reading register 0 clears it. The master reset input is active low and is filtered by a cycle counter: a long enough low pulse returns every register to its default, and a short glitch does nothing. A mode input gates the whole serial port.

Top module: `serial_reg_slave`

## Requirements
- R1: After the system reset is released, `intrN` is 1 and `sdoOe` is 0. Every writable register k holds RESET_BASE + k, and RESET_BASE defaults to 8'hA0.
- R2: `sdi` is sampled on rising edges of `sclk`. Rising edge 1 carries the direction (1 = read, 0 = write). Edges 2 to 7 carry the 6-bit address, most significant bit first. Edge 8 is ignored. Edges 9 to 16 carry data bits 0 to 7.
- R3: In a read frame, data bit n appears on `sdo` after falling edge 8+n, for n from 0 to 7. `sdoOe` is 1 from just after rising edge 1 until chip select returns high.
- R4: A write frame updates its register only on rising edge 16. A frame that chip select ends before that edge leaves every register unchanged.
- R5: Serial clocks beyond the sixteenth within one chip-select-low period have no effect. In particular, a second write packed into the same period is dropped.
- R6: `sdoOe` is 0 whenever chip select is high and throughout a write frame.
- R7: Address 0 reads the alarm inputs, zero-extended, and ignores writes. Addresses 1 to NUM_REGS-1 are read/write, with NUM_REGS defaulting to 8. Every other address reads 0 and ignores writes.
- R8: While `hostMode` is 0, the port ignores all serial activity. It writes nothing and keeps `sdoOe` at 0.
- R9: A registered copy of the alarm inputs is compared against the inputs every system clock. Any difference drives `intrN` low on the next cycle. A difference arriving in the same cycle as a clear keeps `intrN` low.
- R10: A read of address 0 returns `intrN` to 1 at its eighth rising edge. A read of any other address leaves `intrN` unchanged.
- R11: When `mstRstN` stays low for FILTER_CYCLES consecutive system clocks (default 2500, which is 10 us at 250 MHz), every writable register returns to its default. The alarm copy reloads without raising an interrupt, and `intrN` returns to 1. A shorter low pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock that oversamples the serial pins |
| sysRstN | input | 1 | Asynchronous active-low system reset |
| hostMode | input | 1 | 1 enables the serial port; 0 makes it ignore serial activity |
| csN | input | 1 | Active-low chip select framing each access |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdoOe | output | 1 | Output enable for `sdo`; 0 means high impedance |
| intrN | output | 1 | Active-low alarm-change interrupt |
| mstRstN | input | 1 | Active-low master reset, filtered by length |
| alarmIn | input | ALARM_W | Alarm status bits |

## Verification
A wrong bit count or address shift shows up within one frame. The read data comes back as the wrong byte or lands on the wrong bit lanes, and the fault surfaces at the next readback. A commit strobe that fires early, or fires in an aborted or burst frame, damages a register silently. The sweeps therefore write and read back every writable register with several patterns and re-read registers after each ignored-stimulus case. A faulty interrupt latch or reset filter is visible on `intrN` one or two cycles after the alarm edge, and on register contents right after the filtered pulse ends.

// File: rtl/srs_pkg.sv
package srs_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;

  // Rising-edge numbers inside a frame (1-based)
  localparam logic [4:0] BIT_DIR      = 5'd1;
  localparam logic [4:0] BIT_ADDR_LO  = 5'd2;
  localparam logic [4:0] BIT_ADDR_HI  = 5'd7;
  localparam logic [4:0] BIT_TURN     = 5'd8;
  localparam logic [4:0] BIT_DATA_LO  = 5'd9;
  localparam logic [4:0] BIT_LAST     = 5'd16;
  localparam logic [4:0] LAUNCH_FIRST = 5'd8;
  localparam logic [4:0] LAUNCH_LAST  = 5'd15;

  typedef struct packed {
    logic       sampleEn;   // rising serial edge to consume
    logic [4:0] riseNum;    // its 1-based number
    logic       launchEn;   // falling edge that launches read data
    logic [2:0] launchIdx;  // data bit to launch
    logic       frameIdle;  // no frame in progress
    logic       regReset;   // filtered master reset
    logic       sdiBit;     // synchronized serial input
  } ctlStrobe_t;

endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int FILTER_CYCLES = 2500,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       sysClk,
  input  logic       sysRstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       sdi,
  input  logic       hostMode,
  input  logic       mstRstN,
  output ctlStrobe_t strobe,
  output logic [4:0] riseCnt
);

  localparam int PIN_N = 5;
  localparam int CNT_W = $clog2(FILTER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILTER_CYCLES);
  // pin order: sclk, csN, sdi, hostMode, mstRstN
  localparam logic [PIN_N-1:0] PIN_IDLE = 5'b01001;

  logic [SYNC_STAGES-1:0][PIN_N-1:0] syncChain;
  logic [PIN_N-1:0] pinSync;
  logic sclkDly;
  logic [CNT_W-1:0] lowCnt;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) syncChain[0] <= PIN_IDLE;
    else          syncChain[0] <= {sclk, csN, sdi, hostMode, mstRstN};
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge sysClk or negedge sysRstN) begin
        if (!sysRstN) syncChain[s] <= PIN_IDLE;
        else          syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  assign pinSync = syncChain[SYNC_STAGES-1];

  logic sclkS, csS, sdiS, hostS, mstS;
  assign {sclkS, csS, sdiS, hostS, mstS} = pinSync;

  logic frameActive, riseEdge, fallEdge;
  assign frameActive = hostS & ~csS;
  assign riseEdge    = sclkS & ~sclkDly;
  assign fallEdge    = ~sclkS & sclkDly;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      sclkDly <= 1'b0;
      riseCnt <= '0;
    end else begin
      sclkDly <= sclkS;
      if (!frameActive)
        riseCnt <= '0;
      else if (riseEdge && riseCnt != BIT_LAST)
        riseCnt <= riseCnt + 5'd1;
    end
  end

  // master reset length filter
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN)              lowCnt <= '0;
    else if (mstS)             lowCnt <= '0;
    else if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;
  end

  always_comb begin
    strobe.sampleEn  = frameActive & riseEdge & (riseCnt != BIT_LAST);
    strobe.riseNum   = riseCnt + 5'd1;
    strobe.launchEn  = frameActive & fallEdge &
                       (riseCnt >= LAUNCH_FIRST) & (riseCnt <= LAUNCH_LAST);
    strobe.launchIdx = riseCnt[2:0];
    strobe.frameIdle = ~frameActive;
    strobe.regReset  = (lowCnt == CNT_MAX);
    strobe.sdiBit    = sdiS;
  end

endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int              NUM_REGS   = 8,
  parameter int              ALARM_W    = 4,
  parameter logic [DATA_W-1:0] RESET_BASE = 8'hA0
) (
  input  logic                              sysClk,
  input  logic                              sysRstN,
  input  ctlStrobe_t                        strobe,
  input  logic [ALARM_W-1:0]                alarmIn,
  output logic                              sdo,
  output logic                              sdoOe,
  output logic                              intrN,
  output logic [ALARM_W-1:0]                alarmCopy,
  output logic [NUM_REGS-1:1][DATA_W-1:0]   rwRegs
);

  logic              isRead;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rdBuf;
  logic [DATA_W-2:0] wrBuf;
  logic [DATA_W-1:0] readVal;
  logic              intrPend;
  logic              statusClr;
  logic              alarmDiff;
  logic              commitEn;

  // read multiplexer over the address map
  always_comb begin
    readVal = '0;
    if (addr == '0) readVal = DATA_W'(alarmCopy);
    for (int i = 1; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) readVal = rwRegs[i];
  end

  assign statusClr = strobe.sampleEn && strobe.riseNum == BIT_TURN && isRead && addr == '0;
  assign commitEn  = strobe.sampleEn && strobe.riseNum == BIT_LAST && !isRead;
  assign alarmDiff = alarmIn != alarmCopy;

  // frame decode and shifting
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      isRead <= 1'b0;
      addr   <= '0;
      rdBuf  <= '0;
      wrBuf  <= '0;
      sdo    <= 1'b0;
      sdoOe  <= 1'b0;
    end else if (strobe.frameIdle) begin
      isRead <= 1'b0;
      sdo    <= 1'b0;
      sdoOe  <= 1'b0;
    end else begin
      if (strobe.sampleEn) begin
        if (strobe.riseNum == BIT_DIR) begin
          isRead <= strobe.sdiBit;
          sdoOe  <= strobe.sdiBit;
        end else if (strobe.riseNum >= BIT_ADDR_LO && strobe.riseNum <= BIT_ADDR_HI) begin
          addr <= {addr[ADDR_W-2:0], strobe.sdiBit};
        end else if (strobe.riseNum == BIT_TURN) begin
          if (isRead) rdBuf <= readVal;
        end else if (strobe.riseNum < BIT_LAST) begin
          wrBuf[3'(strobe.riseNum - BIT_DATA_LO)] <= strobe.sdiBit;
        end
      end
      if (strobe.launchEn) sdo <= rdBuf[strobe.launchIdx];
    end
  end

  // register file
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      for (int i = 1; i < NUM_REGS; i++) rwRegs[i] <= RESET_BASE + DATA_W'(i);
    end else if (strobe.regReset) begin
      for (int i = 1; i < NUM_REGS; i++) rwRegs[i] <= RESET_BASE + DATA_W'(i);
    end else if (commitEn) begin
      for (int i = 1; i < NUM_REGS; i++)
        if (addr == ADDR_W'(i)) rwRegs[i] <= {strobe.sdiBit, wrBuf};
    end
  end

  // alarm copy and interrupt latch; a change wins over a clear
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      alarmCopy <= '0;
      intrPend  <= 1'b0;
    end else begin
      alarmCopy <= alarmIn;
      if (strobe.regReset)  intrPend <= 1'b0;
      else if (alarmDiff)   intrPend <= 1'b1;
      else if (statusClr)   intrPend <= 1'b0;
    end
  end

  assign intrN = ~intrPend;

endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import srs_pkg::*;
#(
  parameter int                NUM_REGS      = 8,
  parameter int                ALARM_W       = 4,
  parameter logic [DATA_W-1:0] RESET_BASE    = 8'hA0,
  parameter int                FILTER_CYCLES = 2500,
  parameter int                SYNC_STAGES   = 2
) (
  input  logic               sysClk,
  input  logic               sysRstN,
  input  logic               hostMode,
  input  logic               csN,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdoOe,
  output logic               intrN,
  input  logic               mstRstN,
  input  logic [ALARM_W-1:0] alarmIn
);

  ctlStrobe_t strobe;
  logic [4:0] riseCnt;
  logic [ALARM_W-1:0] alarmCopy;
  logic [NUM_REGS-1:1][DATA_W-1:0] rwRegs;

  srs_ctrl #(
    .FILTER_CYCLES(FILTER_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_ctrl (
    .sysClk  (sysClk),
    .sysRstN (sysRstN),
    .sclk    (sclk),
    .csN     (csN),
    .sdi     (sdi),
    .hostMode(hostMode),
    .mstRstN (mstRstN),
    .strobe  (strobe),
    .riseCnt (riseCnt)
  );

  srs_datapath #(
    .NUM_REGS  (NUM_REGS),
    .ALARM_W   (ALARM_W),
    .RESET_BASE(RESET_BASE)
  ) u_dp (
    .sysClk   (sysClk),
    .sysRstN  (sysRstN),
    .strobe   (strobe),
    .alarmIn  (alarmIn),
    .sdo      (sdo),
    .sdoOe    (sdoOe),
    .intrN    (intrN),
    .alarmCopy(alarmCopy),
    .rwRegs   (rwRegs)
  );

endmodule

// File: rtl/serial_reg_slave_chk.sv
module serial_reg_slave_chk
  import srs_pkg::*;
#(
  parameter int                NUM_REGS   = 8,
  parameter int                ALARM_W    = 4,
  parameter logic [DATA_W-1:0] RESET_BASE = 8'hA0
) (
  input logic                            sysClk,
  input logic                            sysRstN,
  input logic [ALARM_W-1:0]              alarmIn,
  input logic [ALARM_W-1:0]              alarmCopy,
  input logic                            intrN,
  input logic                            sdoOe,
  input ctlStrobe_t                      strobe,
  input logic [4:0]                      riseCnt,
  input logic [NUM_REGS-1:1][DATA_W-1:0] rwRegs
);

  logic allDefault;
  always_comb begin
    allDefault = 1'b1;
    for (int i = 1; i < NUM_REGS; i++)
      if (rwRegs[i] != RESET_BASE + DATA_W'(i)) allDefault = 1'b0;
  end

  // R9
  int_set_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (alarmIn != alarmCopy && !strobe.regReset) |=> !intrN);

  // R5
  cnt_cap_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    riseCnt <= BIT_LAST);

  // R6
  oe_idle_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    strobe.frameIdle |=> !sdoOe);

  // R4
  reg_hold_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (!(strobe.sampleEn && strobe.riseNum == BIT_LAST) && !strobe.regReset) |=> $stable(rwRegs));

  // R11
  rst_def_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    strobe.regReset |=> (intrN && allDefault));

endmodule

bind serial_reg_slave serial_reg_slave_chk #(
  .NUM_REGS  (NUM_REGS),
  .ALARM_W   (ALARM_W),
  .RESET_BASE(RESET_BASE)
) u_chk (
  .sysClk   (sysClk),
  .sysRstN  (sysRstN),
  .alarmIn  (alarmIn),
  .alarmCopy(alarmCopy),
  .intrN    (intrN),
  .sdoOe    (sdoOe),
  .strobe   (strobe),
  .riseCnt  (riseCnt),
  .rwRegs   (rwRegs)
);

// File: tb/serial_reg_slave_tb.sv
module serial_reg_slave_tb;

  localparam int NUM_REGS = 8;
  localparam int ALARM_W  = 4;
  localparam logic [7:0] BASE = 8'hA0;
  localparam int FILT = 2500;

  logic sysClk = 1'b0;
  logic sysRstN = 1'b0;
  logic hostMode = 1'b1;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic mstRstN = 1'b1;
  logic [ALARM_W-1:0] alarmIn = '0;
  logic sdo, sdoOe, intrN;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] model [NUM_REGS];

  always #2 sysClk = ~sysClk;

  serial_reg_slave u_dut (
    .sysClk(sysClk), .sysRstN(sysRstN), .hostMode(hostMode), .csN(csN),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe), .intrN(intrN),
    .mstRstN(mstRstN), .alarmIn(alarmIn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  // One chip-select-low period with nClk serial clocks; clocks 17..32 carry a second frame
  task automatic frame(input bit isRd, input logic [5:0] a, input logic [7:0] wd,
                       input logic [7:0] wd2, input int nClk,
                       output logic [7:0] rd, output bit oeAll, output bit oeAny);
    rd = '0; oeAll = 1; oeAny = 0;
    waitc(1); csN = 0; waitc(8);
    for (int k = 1; k <= nClk; k++) begin
      int j = (k > 16) ? k - 16 : k;
      logic [7:0] d = (k > 16) ? wd2 : wd;
      logic b;
      if (j == 1) b = isRd;
      else if (j <= 7) b = a[7 - j];
      else if (j == 8) b = 1'b0;
      else b = d[j - 9];
      sdi = b;
      waitc(8);
      if (k >= 9 && k <= 16) rd[k - 9] = sdo;
      if (k >= 2 && k <= 16) begin oeAll &= sdoOe; oeAny |= sdoOe; end
      sclk = 1; waitc(8); sclk = 0;
    end
    waitc(8); csN = 1; waitc(12);
  endtask

  function automatic logic [7:0] expRead(input int a);
    if (a == 0) return 8'(alarmIn);
    if (a < NUM_REGS) return model[a];
    return 8'h00;
  endfunction

  task automatic rdChk(input int a, input string req);
    logic [7:0] r; bit oa, on;
    frame(1, 6'(a), 8'h00, 8'h00, 16, r, oa, on);
    chk(r == expRead(a), req, r, expRead(a));
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge sysClk);
      cyc++;
      if (cyc > 190000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] r; bit oa, on;
    for (int i = 1; i < NUM_REGS; i++) model[i] = BASE + 8'(i);
    model[0] = 8'h00;
    waitc(4); sysRstN = 1; waitc(4);

    // R1 reset state
    chk(intrN == 1, "R1 intrN", intrN, 1);
    chk(sdoOe == 0, "R1 sdoOe", sdoOe, 0);
    for (int i = 1; i < NUM_REGS; i++) rdChk(i, "R1 default");

    // R7 full address sweep, unmapped reads 0
    for (int a = 0; a < 64; a++) rdChk(a, "R7 address map");

    // R2 R3 write/read sweep over all writable registers
    for (int i = 1; i < NUM_REGS; i++)
      for (int v = 0; v < 256; v += 17) begin
        logic [7:0] wv = 8'(v) ^ 8'(i * 3);
        frame(0, 6'(i), wv, 8'h00, 16, r, oa, on);
        chk(on == 0, "R6 oe during write", on, 0);
        model[i] = wv;
        frame(1, 6'(i), 8'h00, 8'h00, 16, r, oa, on);
        chk(r == wv, "R2 R3 readback", r, wv);
        chk(oa == 1, "R3 oe during read", oa, 1);
        chk(sdoOe == 0, "R6 oe after cs high", sdoOe, 0);
      end

    // R7 writes to status and unmapped addresses ignored
    frame(0, 6'd0, 8'hFF, 8'h00, 16, r, oa, on);
    rdChk(0, "R7 status write ignored");
    frame(0, 6'd40, 8'h5A, 8'h00, 16, r, oa, on);
    rdChk(40, "R7 unmapped write ignored");
    for (int i = 1; i < NUM_REGS; i++) rdChk(i, "R7 no alias");

    // R4 aborted write
    frame(0, 6'd4, 8'h55, 8'h00, 15, r, oa, on);
    rdChk(4, "R4 aborted write");

    // R5 burst: second write in same cs period dropped
    frame(0, 6'd3, 8'h3C, 8'hC3, 32, r, oa, on);
    model[3] = 8'h3C;
    rdChk(3, "R5 burst");

    // R8 hardware mode
    hostMode = 0; waitc(4);
    frame(0, 6'd5, 8'h77, 8'h00, 16, r, oa, on);
    frame(1, 6'd5, 8'h00, 8'h00, 16, r, oa, on);
    chk(on == 0, "R8 no oe in hardware mode", on, 0);
    hostMode = 1; waitc(4);
    rdChk(5, "R8 write ignored");

    // R9 R10 interrupt
    alarmIn = 4'h6; waitc(3);
    chk(intrN == 0, "R9 set on change", intrN, 0);
    rdChk(2, "R10 other read");
    chk(intrN == 0, "R10 other read keeps", intrN, 0);
    rdChk(0, "R10 status value");
    chk(intrN == 1, "R10 status read clears", intrN, 1);
    alarmIn = 4'h2; waitc(3);
    chk(intrN == 0, "R9 second change", intrN, 0);

    // R11 short pulse ignored
    mstRstN = 0; waitc(FILT - 200); mstRstN = 1; waitc(6);
    chk(intrN == 0, "R11 short pulse keeps intr", intrN, 0);
    rdChk(3, "R11 short pulse keeps reg");
    // R11 long pulse restores defaults
    alarmIn = 4'h5;
    mstRstN = 0; waitc(FILT + 50); mstRstN = 1; waitc(6);
    chk(intrN == 1, "R11 intr released", intrN, 1);
    for (int i = 1; i < NUM_REGS; i++) model[i] = BASE + 8'(i);
    for (int i = 0; i < NUM_REGS; i++) rdChk(i, "R11 defaults");
    chk(intrN == 1, "R11 no spurious intr", intrN, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule